// File: doc/BRIEF.md
# Edge-Filtered Status Register Group

This block holds one status group of an instrument-control status hierarchy. Each clock it samples a 16-bit vector of hardware conditions and compares it with the copy it registered on the clock before. When a bit changes, the block checks two programmable masks: one marks the bits whose rising edges count and the other marks the bits whose falling edges count. An edge that one of these masks selects sets the matching bit of a sticky event register. That bit stays set until software clears the register.

An enable mask selects which event bits may reach the level above. The block ANDs the event register with the enable mask and ORs the result into one summary bit, `sum_o`. That bit is meant to drive one bit of a higher-order status register. Software reaches the group through a small register-access port. Through it software writes the three masks and reads the masks, the live condition and the event register. The event register can be read in two ways: a plain read leaves it intact, and a read-and-clear returns it and then empties it. A separate strobe also empties the event register. The most significant bit of every part is reserved: it always reads zero, so every value read back fits a non-negative 15-bit integer.

Top module: `status_group`

## Requirements
- R1: After reset, the rising-edge mask reads 0x7FFF, the falling-edge mask, the enable mask and the event register read 0, and `sum_o` is 0.
- R2: A write with `addr_i` = 1 (rising mask), 2 (falling mask) or 5 (enable mask) updates that mask, and a later read of the same address returns the written value.
- R3: Bit 15 reads 0 in every part, and a write to bit 15 of any mask is ignored.
- R4: A 0-to-1 change of condition bit i sets event bit i only when bit i of the rising mask is 1. Each bit acts independently of every other bit.
- R5: A 1-to-0 change of condition bit i sets event bit i only when bit i of the falling mask is 1.
- R6: An event bit stays set after its condition returns to its former level, until a clear.
- R7: A read with `addr_i` = 4 returns the event register and then clears it. A read with `addr_i` = 3 returns the event register and leaves it unchanged. A one-cycle `clr_i` pulse clears the event register.
- R8: When a qualifying edge occurs in the same cycle as a clear, that event bit is set after the clear. A read-and-clear in that cycle returns the value from before the edge.
- R9: Edges are found by comparing each bit with its value one clock earlier. A condition bit that is high for exactly one cycle therefore gives a rising edge on the first clock and a falling edge on the next.
- R10: `sum_o` equals the OR over all bits of (event AND enable). It follows an enable write or an event set in the same cycle that the new register value appears.
- R11: A read with `addr_i` = 0 returns the current condition input with bit 15 forced to 0. Writes to address 0 or address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 16 | Hardware condition vector, sampled each clock |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 event read-and-clear, 5 enable |
| wdata_i | input | 16 | Write data |
| clr_i | input | 1 | Clear strobe for the event register |
| rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| rdata_o | output | 16 | Read data |
| sum_o | output | 1 | Summary bit: OR of event AND enable |

## Verification
The hardest case to reach from the ports is a qualifying edge that lands in the same clock as a clear. The condition change must line up exactly with the clear strobe, or with a read-and-clear request. The bench drives the new condition value and the clear on the same falling clock edge. It then reads the event register to show that the new bit survived and the old bits were removed. The one-cycle condition pulse is built the same way. The bench drops the condition on the same falling edge on which it issues a read, so that one read captures the state after the rising edge and the next read captures the state after the falling edge.

// File: rtl/status_grp_pkg.sv
package status_grp_pkg;
  typedef enum logic [2:0] {
    A_COND   = 3'd0,
    A_RISE   = 3'd1,
    A_FALL   = 3'd2,
    A_EVT    = 3'd3,
    A_EVT_RC = 3'd4,
    A_ENA    = 3'd5
  } sg_addr_e;
endpackage

// File: rtl/sg_cfg_reg.sv
module sg_cfg_reg #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] VMASK = {1'b0, {(W-1){1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST & VMASK;
    else if (we_i) q_o <= wdata_i & VMASK;
  end

  p_msb_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !q_o[W-1]);
endmodule

// File: rtl/sg_edge_detect.sv
module sg_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == W-1) begin : g_rsvd
      assign set_o[b] = 1'b0;
    end else begin : g_live
      logic rise, fall;
      assign rise     = cond_i[b] & ~cond_q[b];
      assign fall     = ~cond_i[b] & cond_q[b];
      assign set_o[b] = (rise & rise_en_i[b]) | (fall & fall_en_i[b]);
    end
  end

  // a set bit needs a change against the registered history
  p_set_needs_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o & ~(cond_i ^ cond_q)) == '0);
endmodule

// File: rtl/sg_event_bank.sv
module sg_event_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= (clr_i ? '0 : evt_o) | set_i;
  end

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((evt_o & ~$past(set_i)) == '0));
endmodule

// File: rtl/status_group.sv
module status_group
  import status_grp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic         rvalid_o,
  output logic [W-1:0] rdata_o,
  output logic         sum_o
);
  localparam logic [W-1:0] VMASK = {1'b0, {(W-1){1'b1}}};

  sg_addr_e     addr;
  logic         wr, rd;
  logic         we_rise, we_fall, we_ena;
  logic [W-1:0] rise_en, fall_en, ena, evt, set;
  logic         clr_any;
  logic [W-1:0] rd_mux;

  assign addr    = sg_addr_e'(addr_i);
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign we_rise = wr && (addr == A_RISE);
  assign we_fall = wr && (addr == A_FALL);
  assign we_ena  = wr && (addr == A_ENA);
  assign clr_any = clr_i | (rd && (addr == A_EVT_RC));

  sg_cfg_reg #(.W(W), .RST({W{1'b1}})) u_rise (
    .clk_i, .rst_ni, .we_i(we_rise), .wdata_i, .q_o(rise_en));
  sg_cfg_reg #(.W(W), .RST('0)) u_fall (
    .clk_i, .rst_ni, .we_i(we_fall), .wdata_i, .q_o(fall_en));
  sg_cfg_reg #(.W(W), .RST('0)) u_ena (
    .clk_i, .rst_ni, .we_i(we_ena), .wdata_i, .q_o(ena));

  sg_edge_detect #(.W(W)) u_edge (
    .clk_i, .rst_ni, .cond_i, .rise_en_i(rise_en), .fall_en_i(fall_en), .set_o(set));

  sg_event_bank #(.W(W)) u_evt (
    .clk_i, .rst_ni, .set_i(set), .clr_i(clr_any), .evt_o(evt));

  always_comb begin
    unique case (addr)
      A_COND:           rd_mux = cond_i;
      A_RISE:           rd_mux = rise_en;
      A_FALL:           rd_mux = fall_en;
      A_EVT, A_EVT_RC:  rd_mux = evt;
      A_ENA:            rd_mux = ena;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux & VMASK;
    end
  end

  assign sum_o = |(evt & ena);

  // newly set event bits must come from the edge logic
  p_new_evt_from_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt & ~$past(evt) & ~$past(set)) == '0));
  p_rdata_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !rdata_o[W-1]);
  p_sum_needs_ena_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena == '0) |-> !sum_o);
endmodule

// File: tb/sim_status_group.sv
`timescale 1ns/1ps
module sim_status_group;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cond_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0, clr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        rvalid_o, sum_o;
  logic [15:0] rdata_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  status_group u0 (
    .clk_i(clk), .rst_ni, .cond_i, .req_i, .we_i, .addr_i, .wdata_i,
    .clr_i, .rvalid_o, .rdata_o, .sum_o);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    tick();
    req_i = 1'b0;
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "read without request", int'(rdata_o), 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rdata_o == e, t, int'(rdata_o), int'(e));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sum_o == 1'b0, "R1 sum after reset", int'(sum_o), 0);
    rd(3'd1, 16'h7FFF, "R1 rise mask reset");
    rd(3'd2, 16'h0000, "R1 fall mask reset");
    rd(3'd3, 16'h0000, "R1 event reset");
    rd(3'd5, 16'h0000, "R1 enable reset");

    wr(3'd1, 16'hFFFF); rd(3'd1, 16'h7FFF, "R3 rise bit15 ignored");
    wr(3'd5, 16'h8001); rd(3'd5, 16'h0001, "R3 enable bit15 ignored");
    wr(3'd2, 16'h8F0F); rd(3'd2, 16'h0F0F, "R2 fall mask write");
    wr(3'd1, 16'h00FF); rd(3'd1, 16'h00FF, "R2 rise mask write");
    wr(3'd5, 16'h0000); rd(3'd5, 16'h0000, "R2 enable write");

    wr(3'd0, 16'h1234); wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h0000, "R11 event write ignored");
    rd(3'd1, 16'h00FF, "R11 condition write ignored");

    cond_i = 16'h8103; tick();
    rd(3'd3, 16'h0003, "R4 rising filtered by mask");
    rd(3'd0, 16'h0103, "R11 condition readback");
    cond_i = 16'h0000; tick();
    rd(3'd3, 16'h0103, "R5 falling filtered by mask");
    rd(3'd3, 16'h0103, "R6 sticky after plain read");
    rd(3'd4, 16'h0103, "R7 read-and-clear value");
    rd(3'd3, 16'h0000, "R7 cleared by read-and-clear");

    wr(3'd5, 16'h0010);
    chk(sum_o == 1'b0, "R10 sum no event", int'(sum_o), 0);
    cond_i = 16'h0010; tick();
    chk(sum_o == 1'b1, "R10 sum on event set", int'(sum_o), 1);
    wr(3'd5, 16'h0000);
    chk(sum_o == 1'b0, "R10 sum on enable clear", int'(sum_o), 0);
    wr(3'd5, 16'h0010);
    chk(sum_o == 1'b1, "R10 sum on enable set", int'(sum_o), 1);
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    chk(sum_o == 1'b0, "R7 sum after clear strobe", int'(sum_o), 0);
    rd(3'd3, 16'h0000, "R7 clear strobe");

    clr_i = 1'b1; cond_i = 16'h0011; tick(); clr_i = 1'b0;
    rd(3'd3, 16'h0001, "R8 set wins over strobe");
    cond_i = 16'h0013;
    rd(3'd4, 16'h0001, "R8 read-and-clear returns old value");
    rd(3'd3, 16'h0002, "R8 set wins over read-and-clear");

    clr_i = 1'b1; tick(); clr_i = 1'b0;
    cond_i = 16'h0133; tick();
    cond_i = 16'h0013;
    rd(3'd3, 16'h0020, "R9 pulse rising edge");
    rd(3'd3, 16'h0120, "R9 pulse falling edge");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 pending reads", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule